// File: doc/BRIEF.md
# Scanline Timing and CPU Stall Generator

This block produces the horizontal line timing of a retro video chip and lets the host CPU stop until the next line begins. It runs on the colour clock. A free-running horizontal counter steps through a line of 228 colour clocks, which is 76 CPU cycles at three colour clocks per CPU cycle. The first 68 counts of the line are horizontal blank, and a fixed window inside that blank is horizontal sync. The counter drives a four-state phase machine: `PH_LEAD` (blank before sync), `PH_SYNC`, `PH_TAIL` (blank after sync) and `PH_ACTIVE`. The phase moves forward in that order as the count reaches the start of sync, the end of sync and the end of blank. It returns to `PH_LEAD` whenever the count becomes zero.

The CPU writes to the block over a single-cycle write strobe with a 6-bit address and 8-bit data. The block decodes four addresses. The vertical-sync register is at 0x00. The vertical-blank register is at 0x01 and also holds the trigger-latch enable and the pot-dump control. A write to 0x02 stalls the CPU, and a write to 0x03 restarts the line. A two-state stall machine drives the ready output. It has two transitions. `ST_RUN -> ST_HOLD` happens on any write to 0x02. `ST_HOLD -> ST_RUN` happens on the clock where the counter enters count zero, which is the leading edge of horizontal blank. When a stall write and that edge fall on the same clock, the write wins.

Top module: `scan_sync_stall`

## Requirements
- R1: After reset, rdy is 1, hcount is 0, and vsync, vblank, trig_en and pot_dump are all 0.
- R2: hcount advances by one on every clock and wraps from 227 to 0, so each line is 228 clocks long.
- R3: hblank is 1 exactly when hcount is below 68.
- R4: hsync is 1 exactly when hcount is in the range 20 to 35 inclusive, which lies inside horizontal blank.
- R5: A write to address 0x00 loads data bit 1 into vsync on the next clock. The other data bits have no effect.
- R6: A write to address 0x01 loads data bit 1 into vblank, data bit 6 into trig_en and data bit 7 into pot_dump on the next clock.
- R7: A write to address 0x02 drives rdy to 0 from the next clock, whatever the data value.
- R8: While stalled, rdy stays 0 until the clock at which hcount becomes 0. From that point rdy reads 1.
- R9: A write to address 0x02 on the same clock as hcount wraps to 0 leaves rdy at 0 for the whole following line of 228 clocks.
- R10: A write to address 0x03 sets hcount to 0 on the next clock. This starts horizontal blank and releases a pending stall.
- R11: Writes to addresses 0x04 to 0x3F, and any cycle with wr_en at 0, change no output beyond normal counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_addr | input | 6 | Register address |
| wr_data | input | 8 | Write data |
| hcount | output | 8 | Current horizontal count, 0 to 227 |
| hblank | output | 1 | Horizontal blank |
| hsync | output | 1 | Horizontal sync pulse |
| vsync | output | 1 | Vertical sync latch |
| vblank | output | 1 | Vertical blank latch |
| trig_en | output | 1 | Trigger input latch enable |
| pot_dump | output | 1 | Pot inputs dumped to ground |
| rdy | output | 1 | CPU ready; 0 stalls the CPU |

## Verification
The bench models the count, the phase windows and the ready latch arithmetically and compares every output on every clock. It issues stall writes at mid-line, at count 227 (where the write and the wrap land on the same clock) and just before a line restart. A design that gives the release priority over the write would let the CPU run a full line early in the coincident case. A design that ignores a restart as a line edge would keep the CPU stalled through the rest of the line. The bench also sweeps all 64 addresses with all-ones and all-zeros data, and it includes strobe-low cycles. This catches decoders that look at too few address bits or that act on data bits other than the specified ones.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_VSYNC  = 6'h00;
    localparam logic [ADDR_W-1:0] ADR_VBLANK = 6'h01;
    localparam logic [ADDR_W-1:0] ADR_WAIT   = 6'h02;
    localparam logic [ADDR_W-1:0] ADR_RESYNC = 6'h03;

    typedef enum logic [1:0] {
        PH_LEAD   = 2'd0,
        PH_SYNC   = 2'd1,
        PH_TAIL   = 2'd2,
        PH_ACTIVE = 2'd3
    } line_phase_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } stall_state_e;

endpackage

// File: rtl/scan_hcounter.sv
module scan_hcounter
    import scan_pkg::*;
#(
    parameter int LINE_CLKS   = 228,
    parameter int HBLANK_CLKS = 68,
    parameter int HSYNC_START = 20,
    parameter int HSYNC_LEN   = 16,
    localparam int CW = $clog2(LINE_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] hcount,
    output logic          line_start,
    output logic          hblank,
    output logic          hsync
);

    localparam logic [CW-1:0] LAST     = CW'(LINE_CLKS - 1);
    localparam logic [CW-1:0] SYNC_BEG = CW'(HSYNC_START);
    localparam logic [CW-1:0] SYNC_END = CW'(HSYNC_START + HSYNC_LEN);
    localparam logic [CW-1:0] BLK_END  = CW'(HBLANK_CLKS);

    logic [CW-1:0] cnt_q, cnt_d;
    line_phase_e   phase_q, phase_d;

    always_comb begin
        if (restart || cnt_q == LAST) cnt_d = '0;
        else                          cnt_d = cnt_q + 1'b1;
    end

    assign line_start = (cnt_d == '0);

    // phase transitions taken on the count being entered
    always_comb begin
        phase_d = phase_q;
        if (line_start) begin
            phase_d = PH_LEAD;
        end else begin
            unique case (phase_q)
                PH_LEAD:   if (cnt_d == SYNC_BEG) phase_d = PH_SYNC;
                PH_SYNC:   if (cnt_d == SYNC_END) phase_d = PH_TAIL;
                PH_TAIL:   if (cnt_d == BLK_END)  phase_d = PH_ACTIVE;
                PH_ACTIVE: phase_d = PH_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= PH_LEAD;
        end else begin
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
        end
    end

    always_comb begin
        hcount = cnt_q;
        hblank = (phase_q != PH_ACTIVE);
        hsync  = (phase_q == PH_SYNC);
    end

endmodule

// File: rtl/scan_stall.sv
module scan_stall
    import scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wait_wr,
    input  logic line_start,
    output logic rdy
);

    stall_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  if (wait_wr) st_d = ST_HOLD;
            ST_HOLD: if (line_start && !wait_wr) st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        rdy = (st_q == ST_RUN);
    end

endmodule

// File: rtl/scan_vregs.sv
module scan_vregs (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_wr,
    input  logic vb_wr,
    input  logic d_sync,
    input  logic d_trig,
    input  logic d_dump,
    output logic vsync,
    output logic vblank,
    output logic trig_en,
    output logic pot_dump
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsync    <= 1'b0;
            vblank   <= 1'b0;
            trig_en  <= 1'b0;
            pot_dump <= 1'b0;
        end else begin
            if (vs_wr) vsync <= d_sync;
            if (vb_wr) begin
                vblank   <= d_sync;
                trig_en  <= d_trig;
                pot_dump <= d_dump;
            end
        end
    end

endmodule

// File: rtl/scan_sync_stall.sv
module scan_sync_stall
    import scan_pkg::*;
#(
    parameter int LINE_CLKS   = 228,
    parameter int HBLANK_CLKS = 68,
    parameter int HSYNC_START = 20,
    parameter int HSYNC_LEN   = 16,
    localparam int CW = $clog2(LINE_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CW-1:0]     hcount,
    output logic              hblank,
    output logic              hsync,
    output logic              vsync,
    output logic              vblank,
    output logic              trig_en,
    output logic              pot_dump,
    output logic              rdy
);

    logic sel_vs, sel_vb, sel_wait, sel_resync, line_start;
    logic unused_data;

    assign sel_vs      = wr_en && (wr_addr == ADR_VSYNC);
    assign sel_vb      = wr_en && (wr_addr == ADR_VBLANK);
    assign sel_wait    = wr_en && (wr_addr == ADR_WAIT);
    assign sel_resync  = wr_en && (wr_addr == ADR_RESYNC);
    assign unused_data = ^{wr_data[5:2], wr_data[0]};

    scan_hcounter #(
        .LINE_CLKS  (LINE_CLKS),
        .HBLANK_CLKS(HBLANK_CLKS),
        .HSYNC_START(HSYNC_START),
        .HSYNC_LEN  (HSYNC_LEN)
    ) u_hcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (sel_resync),
        .hcount    (hcount),
        .line_start(line_start),
        .hblank    (hblank),
        .hsync     (hsync)
    );

    scan_stall u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_wr   (sel_wait),
        .line_start(line_start),
        .rdy       (rdy)
    );

    scan_vregs u_vregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .vs_wr   (sel_vs),
        .vb_wr   (sel_vb),
        .d_sync  (wr_data[1]),
        .d_trig  (wr_data[6]),
        .d_dump  (wr_data[7]),
        .vsync   (vsync),
        .vblank  (vblank),
        .trig_en (trig_en),
        .pot_dump(pot_dump)
    );

endmodule

// File: rtl/scan_sync_chk.sv
module scan_sync_chk
    import scan_pkg::*;
#(
    parameter int LINE_CLKS = 228,
    localparam int CW = $clog2(LINE_CLKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              d_bit1,
    input logic [CW-1:0]     hcount,
    input logic              hblank,
    input logic              hsync,
    input logic              vsync,
    input logic              rdy
);

    localparam logic [CW-1:0] LAST = CW'(LINE_CLKS - 1);

    logic is_wait, is_resync, is_vs;
    assign is_wait   = wr_en && wr_addr == ADR_WAIT;
    assign is_resync = wr_en && wr_addr == ADR_RESYNC;
    assign is_vs     = wr_en && wr_addr == ADR_VSYNC;

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount == LAST && !is_resync) |=> hcount == '0);

    // R4
    sync_inside_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> hblank);

    // R5
    vsync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_vs |=> vsync == $past(d_bit1));

    // R7
    stall_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_wait |=> !rdy);

    // R8
    release_at_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> hcount == '0);

    // R8
    hold_mid_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && hcount != LAST && !is_resync) |=> !rdy);

    // R10
    restart_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_resync |=> hcount == '0);

endmodule

bind scan_sync_stall scan_sync_chk #(.LINE_CLKS(LINE_CLKS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .d_bit1 (wr_data[1]),
    .hcount (hcount),
    .hblank (hblank),
    .hsync  (hsync),
    .vsync  (vsync),
    .rdy    (rdy)
);

// File: tb/tb_scan_sync_stall.sv
module tb_scan_sync_stall;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] hcount;
    logic       hblank, hsync, vsync, vblank, trig_en, pot_dump, rdy;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    // bench model
    int   m_h = 0;
    logic m_rdy = 1'b1, m_vs = 1'b0, m_vb = 1'b0, m_tr = 1'b0, m_dp = 1'b0;

    always #4 clk = ~clk;

    scan_sync_stall dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hcount(hcount), .hblank(hblank), .hsync(hsync), .vsync(vsync), .vblank(vblank),
        .trig_en(trig_en), .pot_dump(pot_dump), .rdy(rdy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at t=%0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2/R10 hcount", int'(hcount), m_h);
        chk("R3 hblank", int'(hblank), int'(m_h < 68));
        chk("R4 hsync", int'(hsync), int'(m_h >= 20 && m_h <= 35));
        chk("R5 vsync", int'(vsync), int'(m_vs));
        chk("R6 vblank", int'(vblank), int'(m_vb));
        chk("R6 trig_en", int'(trig_en), int'(m_tr));
        chk("R6 pot_dump", int'(pot_dump), int'(m_dp));
        chk("R7/R8/R9 rdy", int'(rdy), int'(m_rdy));
    endtask

    // one clock with the given bus values; inputs driven and checked at negedge
    task automatic cyc(input logic we, input logic [5:0] a, input logic [7:0] d);
        int nh;
        wr_en = we; wr_addr = a; wr_data = d;
        nh = (we && a == 6'h03) ? 0 : ((m_h == 227) ? 0 : m_h + 1);
        if (we && a == 6'h02)      m_rdy = 1'b0;
        else if (nh == 0)          m_rdy = 1'b1;
        if (we && a == 6'h00) m_vs = d[1];
        if (we && a == 6'h01) begin m_vb = d[1]; m_tr = d[6]; m_dp = d[7]; end
        m_h = nh;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 6'h00, 8'h00);
    endtask

    task automatic idle_to(input int h);
        while (m_h != h) cyc(1'b0, 6'h00, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state before first active edge
        compare_all();
        chk("R1 rdy after reset", int'(rdy), 1);

        // R2 R3 R4: two full lines, every count
        idle(456);

        // R5: only bit 1 matters
        cyc(1'b1, 6'h00, 8'h02);
        cyc(1'b1, 6'h00, 8'hFD);
        cyc(1'b1, 6'h00, 8'hFF);
        cyc(1'b1, 6'h00, 8'h00);

        // R6
        cyc(1'b1, 6'h01, 8'hC2);
        cyc(1'b1, 6'h01, 8'h40);
        cyc(1'b1, 6'h01, 8'h82);
        cyc(1'b1, 6'h01, 8'h00);

        // R7 R8: stall mid-line, data zero, hold until wrap
        idle_to(100);
        cyc(1'b1, 6'h02, 8'h00);
        chk("R7 rdy low after wait write", int'(rdy), 0);
        idle_to(0);
        chk("R8 rdy high at line start", int'(rdy), 1);
        idle(10);

        // R9: wait write on the wrap clock
        idle_to(227);
        cyc(1'b1, 6'h02, 8'hFF);
        chk("R9 rdy low at coincident edge", int'(rdy), 0);
        idle(227);
        chk("R9 still stalled at 227", int'(rdy), 0);
        cyc(1'b0, 6'h00, 8'h00);
        chk("R9 released next line", int'(rdy), 1);

        // R10: restart mid-line, and restart releasing a stall
        idle_to(150);
        cyc(1'b1, 6'h03, 8'hAA);
        chk("R10 hcount zero after restart", int'(hcount), 0);
        idle_to(90);
        cyc(1'b1, 6'h02, 8'h55);
        idle(5);
        cyc(1'b1, 6'h03, 8'h00);
        chk("R10 restart releases stall", int'(rdy), 1);
        idle(300);

        // R11: all addresses, both data extremes, plus strobe-low cycles
        for (int a = 0; a < 64; a++) begin
            cyc(1'b1, 6'(a), 8'hFF);
            cyc(1'b0, 6'h02, 8'hFF);
            cyc(1'b0, 6'h03, 8'hFF);
            cyc(1'b1, 6'(a), 8'h00);
            idle(3);
        end
        idle(460);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule